// File: doc/BRIEF.md
# Flash Byte Program and Completion Poll Controller

This block sits on the host side of an asynchronous parallel flash bus. It drives active-low chip, output and write enables, an address bus and a data bus split into output, drive-enable and input halves for the pad ring. One request programs a single byte or erases the whole device. For a byte program the block sends either the full three-write unlock preamble or, when the flash has already been put into its bypass state, only the program opcode. It then writes the target byte. An erase always uses the six-write sequence.

After the last command write the block watches the device's embedded algorithm in one of two ways, chosen per request. Toggle polling compares bit 6 across back-to-back status reads. Data polling compares bit 7 read at the target address with the value written. Error bit 5 triggers one confirming step. A cycle-count timeout stops a device that never finishes. When the result is a failure, the block writes the reset opcode before it reports. Every strobe width is a parameter in clock cycles.

Top module: `fpc_prog_ctrl`

## Requirements
- R1: A program request with bypass low issues exactly four writes: data AAh at address 555h, 55h at 2AAh, A0h at 555h, then the request byte at the request address. Command addresses have all bits above bit 10 at zero.
- R2: A program request with bypass high issues exactly two writes: A0h at 555h, then the request byte at the request address.
- R3: An erase request issues exactly six writes, whatever the bypass input is: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h.
- R4: Write enable is low only while chip enable is low and output enable is high.
- R5: Each write-enable low pulse lasts at least max(WE_LOW_CYC, DS_CYC) cycles. The data bus is driven and stable for the whole pulse. Write enable stays high for at least WE_HIGH_CYC cycles between pulses.
- R6: The data-bus drive enable is low in the cycle before output enable falls, and it stays low for as long as output enable is low.
- R7: Toggle polling reports pass when bit 6 is equal on two consecutive status reads.
- R8: In toggle polling, a pair of reads whose bit 6 differs and whose second read has bit 5 set is followed by two more reads. The result is fail if bit 6 still differs and pass if it matches. With bit 5 clear, polling restarts.
- R9: Data polling reads at the request address. Bit 7 equal to the expected bit gives pass. The expected bit is the written bit 7 for a program and 1 for an erase. A mismatch with bit 5 set leads to exactly one re-read, which decides pass or fail. A mismatch with bit 5 clear continues polling.
- R10: A failed operation ends with a write of F0h before done is reported. Requests made while busy are ignored.
- R11: If polling reaches no result within TIMEOUT_CYC cycles, the result is fail.
- R12: After reset, busy and done are low, all three enables are high and the data drive is off. Done is a one-cycle pulse with busy high, and the result is valid on pass during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an operation (sampled while idle) |
| erase_i | input | 1 | 1: whole-device erase, 0: byte program |
| bypass_i | input | 1 | Use the short program preamble |
| data_poll_i | input | 1 | 1: data polling, 0: toggle polling |
| addr_i | input | AW | Target byte address |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid with done_o |
| fl_addr_o | output | AW | Flash address bus |
| fl_data_o | output | 8 | Flash data bus, outgoing value |
| fl_data_oe_o | output | 1 | Flash data bus drive enable |
| fl_data_i | input | 8 | Flash data bus, incoming value |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_we_no | output | 1 | Write enable, active low |

## Verification
The bench builds the block with WE_LOW_CYC=4, DS_CYC=3, WE_HIGH_CYC=2 and RD_CYC=3. These values make the 40 ns, 30 ns and 20 ns minimums measurable at 10 ns resolution. Because the write pulse length is the larger of two parameters, a wrong choice between them shows up as a short pulse. TIMEOUT_CYC is set to 300, so a device model that never finishes trips the timeout after a few dozen status reads. The model also covers the case where bit 5 rises on the last busy read, so the confirming reads are exercised in both polling modes.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int  POLL_BIT  = 7;
  localparam int  TOG_BIT   = 6;
  localparam int  ERR_BIT   = 5;
  localparam logic [7:0] CMD_CLEAR = 8'hF0;

  typedef struct packed {
    logic [10:0] addr;
    logic [7:0]  data;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_CMD_WAIT, S_POLL, S_POLL_WAIT, S_RST, S_RST_WAIT, S_DONE
  } ctl_state_e;

  typedef enum logic [2:0] {
    B_IDLE, B_W_SET, B_W_LOW, B_W_HIGH, B_R_TURN, B_R_ACC, B_R_END
  } bus_state_e;

  // number of command writes that precede the target write
  function automatic logic [2:0] unlock_len(input logic erase, input logic bypass);
    if (erase)       return 3'd6;
    else if (bypass) return 3'd1;
    else             return 3'd3;
  endfunction

  function automatic cmd_t unlock_cmd(input logic erase, input logic bypass,
                                      input logic [2:0] idx);
    cmd_t c;
    if (erase) begin
      case (idx)
        3'd0, 3'd3: c = '{addr: 11'h555, data: 8'hAA};
        3'd1, 3'd4: c = '{addr: 11'h2AA, data: 8'h55};
        3'd2:       c = '{addr: 11'h555, data: 8'h80};
        default:    c = '{addr: 11'h555, data: 8'h10};
      endcase
    end else if (bypass) begin
      c = '{addr: 11'h555, data: 8'hA0};
    end else begin
      case (idx)
        3'd0:    c = '{addr: 11'h555, data: 8'hAA};
        3'd1:    c = '{addr: 11'h2AA, data: 8'h55};
        default: c = '{addr: 11'h555, data: 8'hA0};
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/fpc_poll_timer.sv
module fpc_poll_timer #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  p_expire_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clear_i) |=> expired_o);

endmodule

// File: rtl/fpc_bus_cycle.sv
module fpc_bus_cycle
  import fpc_pkg::*;
#(
  parameter int AW         = 16,
  parameter int WE_PULSE   = 4,
  parameter int WE_HIGH_CYC = 2,
  parameter int RD_CYC     = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_data_o,
  output logic          fl_data_oe_o,
  input  logic [7:0]    fl_data_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);
  localparam int CMAX = (WE_PULSE > WE_HIGH_CYC) ?
                        ((WE_PULSE > RD_CYC) ? WE_PULSE : RD_CYC) :
                        ((WE_HIGH_CYC > RD_CYC) ? WE_HIGH_CYC : RD_CYC);
  localparam int CW = $clog2(CMAX + 1);

  bus_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        B_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cnt_q   <= '0;
          st_q    <= wr_i ? B_W_SET : B_R_TURN;
        end
        B_W_SET: st_q <= B_W_LOW;
        B_W_LOW: if (cnt_q == CW'(WE_PULSE - 1)) begin
          cnt_q <= '0;
          st_q  <= B_W_HIGH;
        end else cnt_q <= cnt_q + 1'b1;
        B_W_HIGH: if (cnt_q == CW'(WE_HIGH_CYC - 1)) begin
          st_q   <= B_IDLE;
          done_o <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        B_R_TURN: st_q <= B_R_ACC;
        B_R_ACC: if (cnt_q == CW'(RD_CYC - 1)) begin
          rdata_o <= fl_data_i;
          st_q    <= B_R_END;
        end else cnt_q <= cnt_q + 1'b1;
        B_R_END: begin
          st_q   <= B_IDLE;
          done_o <= 1'b1;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign fl_addr_o    = addr_q;
  assign fl_data_o    = wdata_q;
  assign fl_data_oe_o = st_q inside {B_W_SET, B_W_LOW, B_W_HIGH};
  assign fl_ce_no     = !(st_q inside {B_W_SET, B_W_LOW, B_W_HIGH, B_R_TURN, B_R_ACC});
  assign fl_we_no     = (st_q != B_W_LOW);
  assign fl_oe_no     = (st_q != B_R_ACC);

  // checker-side count of consecutive write-enable low cycles
  logic [CW-1:0] chk_wl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           chk_wl_q <= '0;
    else if (fl_we_no)                     chk_wl_q <= '0;
    else if (chk_wl_q != CW'(CMAX))        chk_wl_q <= chk_wl_q + 1'b1;
  end

  p_we_only_in_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (fl_oe_no && !fl_ce_no));
  p_we_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (chk_wl_q >= CW'(WE_PULSE)));
  p_data_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_data_o) && fl_data_oe_o));
  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_data_oe_o);
  p_release_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_oe_no) |-> !$past(fl_data_oe_o));

endmodule

// File: rtl/fpc_prog_ctrl.sv
module fpc_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int AW          = 16,
  parameter int WE_LOW_CYC  = 4,
  parameter int DS_CYC      = 3,
  parameter int WE_HIGH_CYC = 2,
  parameter int RD_CYC      = 5,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          erase_i,
  input  logic          bypass_i,
  input  logic          data_poll_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_data_o,
  output logic          fl_data_oe_o,
  input  logic [7:0]    fl_data_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);
  localparam int WE_PULSE = (WE_LOW_CYC > DS_CYC) ? WE_LOW_CYC : DS_CYC;

  ctl_state_e    st_q;
  logic          erase_q, bypass_q, dpoll_q, pass_q, tog_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step_q;
  logic [1:0]    idx_q;

  logic          bus_start, bus_wr, bus_done;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          expired;

  logic [2:0] n_unlock, last_step;
  cmd_t       ucmd;
  logic       exp7, hit, same, dec_pass, dec_fail;
  logic [1:0] nxt_idx;
  logic       unused_rd;

  assign n_unlock  = unlock_len(erase_q, bypass_q);
  assign last_step = erase_q ? n_unlock - 3'd1 : n_unlock;
  assign ucmd      = unlock_cmd(erase_q, bypass_q, step_q);
  assign exp7      = erase_q | data_q[7];
  assign unused_rd = ^bus_rdata[4:0];

  always_comb begin
    bus_start = st_q inside {S_CMD, S_POLL, S_RST};
    bus_wr    = (st_q != S_POLL);
    bus_addr  = addr_q;
    bus_wdata = data_q;
    if (st_q == S_RST) begin
      bus_addr  = '0;
      bus_wdata = CMD_CLEAR;
    end else if (st_q == S_CMD && step_q < n_unlock) begin
      bus_addr  = AW'(ucmd.addr);
      bus_wdata = ucmd.data;
    end
  end

  // poll decision on each completed status read
  always_comb begin
    hit      = (bus_rdata[POLL_BIT] == exp7);
    same     = (bus_rdata[TOG_BIT] == tog_q);
    dec_pass = 1'b0;
    dec_fail = 1'b0;
    nxt_idx  = 2'd0;
    if (dpoll_q) begin
      if (idx_q == 2'd0) begin
        if (hit)                     dec_pass = 1'b1;
        else if (bus_rdata[ERR_BIT]) nxt_idx  = 2'd1;
        else if (expired)            dec_fail = 1'b1;
      end else begin
        dec_pass = hit;
        dec_fail = !hit;
      end
    end else begin
      case (idx_q)
        2'd0: nxt_idx = 2'd1;
        2'd1: begin
          if (same)                    dec_pass = 1'b1;
          else if (bus_rdata[ERR_BIT]) nxt_idx  = 2'd2;
          else if (expired)            dec_fail = 1'b1;
        end
        2'd2: nxt_idx = 2'd3;
        default: begin
          dec_pass = same;
          dec_fail = !same;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      erase_q  <= 1'b0;
      bypass_q <= 1'b0;
      dpoll_q  <= 1'b0;
      pass_q   <= 1'b0;
      tog_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      step_q   <= '0;
      idx_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_i) begin
          erase_q  <= erase_i;
          bypass_q <= bypass_i;
          dpoll_q  <= data_poll_i;
          addr_q   <= addr_i;
          data_q   <= data_i;
          step_q   <= '0;
          st_q     <= S_CMD;
        end
        S_CMD: st_q <= S_CMD_WAIT;
        S_CMD_WAIT: if (bus_done) begin
          if (step_q == last_step) begin
            idx_q <= '0;
            st_q  <= S_POLL;
          end else begin
            step_q <= step_q + 3'd1;
            st_q   <= S_CMD;
          end
        end
        S_POLL: st_q <= S_POLL_WAIT;
        S_POLL_WAIT: if (bus_done) begin
          tog_q <= bus_rdata[TOG_BIT];
          if (dec_pass) begin
            pass_q <= 1'b1;
            st_q   <= S_DONE;
          end else if (dec_fail) begin
            pass_q <= 1'b0;
            st_q   <= S_RST;
          end else begin
            idx_q <= nxt_idx;
            st_q  <= S_POLL;
          end
        end
        S_RST: st_q <= S_RST_WAIT;
        S_RST_WAIT: if (bus_done) st_q <= S_DONE;
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);
  assign pass_o = pass_q;

  fpc_bus_cycle #(
    .AW(AW), .WE_PULSE(WE_PULSE), .WE_HIGH_CYC(WE_HIGH_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk_i, .rst_ni,
    .start_i(bus_start), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .done_o(bus_done), .rdata_o(bus_rdata),
    .fl_addr_o, .fl_data_o, .fl_data_oe_o, .fl_data_i,
    .fl_ce_no, .fl_oe_no, .fl_we_no
  );

  fpc_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni,
    .clear_i(st_q == S_IDLE),
    .run_i(st_q inside {S_POLL, S_POLL_WAIT}),
    .expired_o(expired)
  );

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> (fl_ce_no && fl_we_no && fl_oe_no && !fl_data_oe_o));
  p_fail_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> ($past(st_q) == S_RST_WAIT));

endmodule

// File: tb/tb_fpc_prog_ctrl.sv
module tb_fpc_prog_ctrl;

  localparam int AW = 16;
  localparam int WE_LOW_CYC = 4, DS_CYC = 3, WE_HIGH_CYC = 2, RD_CYC = 3;
  localparam int TIMEOUT_CYC = 300;
  localparam int PULSE_NS = 10 * ((WE_LOW_CYC > DS_CYC) ? WE_LOW_CYC : DS_CYC);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, erase_i = 1'b0, bypass_i = 1'b0, data_poll_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic busy_o, done_o, pass_o, fl_data_oe_o, fl_ce_no, fl_oe_no, fl_we_no;
  logic [AW-1:0] fl_addr_o;
  logic [7:0] fl_data_o, fl_data_i;

  always #5 clk = ~clk;

  fpc_prog_ctrl #(
    .AW(AW), .WE_LOW_CYC(WE_LOW_CYC), .DS_CYC(DS_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .RD_CYC(RD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dut (
    .clk_i(clk), .rst_ni, .req_i, .erase_i, .bypass_i, .data_poll_i, .addr_i, .data_i,
    .busy_o, .done_o, .pass_o, .fl_addr_o, .fl_data_o, .fl_data_oe_o, .fl_data_i,
    .fl_ce_no, .fl_oe_no, .fl_we_no
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  int         m_busy = 0;
  bit         m_fail = 0, m_race = 0;
  bit         st_active = 0, armed = 0;
  logic [7:0] pd = 8'hFF;
  int         rdcnt = 0;
  int         wcnt = 0;
  logic [AW-1:0] wlog_a [16];
  logic [7:0]    wlog_d [16];
  logic [7:0]    rd_val;

  always @(posedge fl_we_no) if (rst_ni) begin
    if (wcnt < 16) begin
      wlog_a[wcnt] = fl_addr_o;
      wlog_d[wcnt] = fl_data_o;
    end
    wcnt++;
    if (armed) begin
      armed = 0; st_active = 1; pd = fl_data_o; rdcnt = 0;
    end else if (fl_data_o == 8'hF0) begin
      st_active = 0;
    end else if (fl_data_o == 8'hA0) begin
      armed = 1;
    end else if (fl_data_o == 8'h10) begin
      st_active = 1; pd = 8'hFF; rdcnt = 0;
    end
  end

  always @(posedge fl_oe_no) if (rst_ni) rdcnt++;

  always_comb begin
    bit err;
    err = m_fail ? (rdcnt >= m_busy) : (m_race && rdcnt == m_busy - 1);
    if (st_active && (m_fail || rdcnt < m_busy))
      rd_val = {~pd[7], rdcnt[0], err, 5'b0};
    else
      rd_val = pd;
  end
  assign fl_data_i = (!fl_ce_no && !fl_oe_no) ? rd_val : 8'h00;

  // ---------------- bus timing monitors ----------------
  time t_fall = 0, t_rise = 0;
  bit  had_rise = 0;
  logic [7:0] d_fall = '0;
  int  v_r4 = 0, v_r5 = 0, v_r6 = 0;

  always @(negedge fl_we_no) if (rst_ni) begin
    t_fall = $time;
    d_fall = fl_data_o;
    if (!fl_oe_no || fl_ce_no) v_r4++;
    if (!fl_data_oe_o) v_r5++;
    if (had_rise && ($time - t_rise) < 10 * WE_HIGH_CYC) v_r5++;
  end
  always @(posedge fl_we_no) if (rst_ni) begin
    if (($time - t_fall) < PULSE_NS) v_r5++;
    if (fl_data_o !== d_fall) v_r5++;
    t_rise = $time;
    had_rise = 1;
  end
  always @(negedge fl_oe_no) if (rst_ni && fl_data_oe_o) v_r6++;
  always @(negedge clk) if (rst_ni && !fl_oe_no && fl_data_oe_o) v_r6++;

  // ---------------- stimulus vectors ----------------
  typedef struct packed {
    logic       er, by, dp;
    logic [7:0] busy;
    logic       fl, rc;
    logic [15:0] a;
    logic [7:0] d;
    logic       ep;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 8'd3,   1'b0, 1'b0, 16'h1234, 8'h3C, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd2,   1'b0, 1'b0, 16'h0ABC, 8'h81, 1'b1},
    '{1'b0, 1'b0, 1'b1, 8'd4,   1'b0, 1'b0, 16'hF00F, 8'hA5, 1'b1},
    '{1'b0, 1'b1, 1'b1, 8'd1,   1'b0, 1'b1, 16'h0555, 8'h7E, 1'b1},
    '{1'b0, 1'b0, 1'b0, 8'd2,   1'b0, 1'b1, 16'h2222, 8'hC3, 1'b1},
    '{1'b0, 1'b0, 1'b0, 8'd2,   1'b1, 1'b0, 16'h3333, 8'h11, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'd1,   1'b1, 1'b0, 16'h4444, 8'h92, 1'b0},
    '{1'b1, 1'b0, 1'b0, 8'd3,   1'b0, 1'b0, 16'h0000, 8'hFF, 1'b1},
    '{1'b1, 1'b1, 1'b1, 8'd2,   1'b0, 1'b0, 16'h0100, 8'hFF, 1'b1},
    '{1'b1, 1'b0, 1'b1, 8'd2,   1'b1, 1'b0, 16'h0200, 8'hFF, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'd255, 1'b0, 1'b0, 16'h5555, 8'h66, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'd255, 1'b0, 1'b0, 16'h6666, 8'hE7, 1'b0}
  };

  function automatic logic [23:0] exp_wr(input vec_t v, input int i);
    if (v.er) begin
      case (i)
        0, 3:    return {16'h0555, 8'hAA};
        1, 4:    return {16'h02AA, 8'h55};
        2:       return {16'h0555, 8'h80};
        default: return {16'h0555, 8'h10};
      endcase
    end else if (v.by) begin
      return (i == 0) ? {16'h0555, 8'hA0} : {v.a, v.d};
    end else begin
      case (i)
        0:       return {16'h0555, 8'hAA};
        1:       return {16'h02AA, 8'h55};
        2:       return {16'h0555, 8'hA0};
        default: return {v.a, v.d};
      endcase
    end
  endfunction

  function automatic string wr_tag(input vec_t v);
    return v.er ? "R3" : (v.by ? "R2" : "R1");
  endfunction

  function automatic string res_tag(input vec_t v);
    if (v.busy == 8'd255) return "R11";
    if (v.dp)             return "R9";
    if (v.fl || v.rc)     return "R8";
    return "R7";
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input vec_t v, input bit poke_busy);
    int n, base;
    logic [23:0] e;
    bit seen;
    m_busy = int'(v.busy); m_fail = v.fl; m_race = v.rc;
    wcnt = 0;
    @(negedge clk);
    erase_i = v.er; bypass_i = v.by; data_poll_i = v.dp; addr_i = v.a; data_i = v.d;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      addr_i = 16'h7777; data_i = 8'h00; req_i = 1'b1;   // R10: ignored while busy
      @(negedge clk);
      req_i = 1'b0;
    end
    seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R12", "done seen", {31'b0, seen}, 32'd1);
    check(busy_o == 1'b1, "R12", "busy with done", {31'b0, busy_o}, 32'd1);
    check(pass_o == v.ep, res_tag(v), "result", {31'b0, pass_o}, {31'b0, v.ep});
    @(negedge clk);
    check(done_o == 1'b0, "R12", "done one cycle", {31'b0, done_o}, 32'd0);
    base = v.er ? 6 : (v.by ? 2 : 4);
    n = base + (v.ep ? 0 : 1);
    check(wcnt == n, wr_tag(v), "write count", wcnt, n);
    for (int i = 0; i < base && i < wcnt; i++) begin
      e = exp_wr(v, i);
      check({wlog_a[i], wlog_d[i]} == e, wr_tag(v), "write addr/data",
            {8'h0, wlog_a[i], wlog_d[i]}, {8'h0, e});
    end
    if (!v.ep && wcnt == n)
      check(wlog_d[n-1] == 8'hF0, "R10", "clear write after fail",
            {24'h0, wlog_d[n-1]}, 32'hF0);
  endtask

  initial begin
    // reset state R12
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R12", "reset busy/done",
          {30'b0, busy_o, done_o}, 32'd0);
    check({fl_ce_no, fl_oe_no, fl_we_no, fl_data_oe_o} == 4'b1110, "R12", "reset strobes",
          {28'b0, fl_ce_no, fl_oe_no, fl_we_no, fl_data_oe_o}, 32'hE);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

    // R10: a request during busy must not start a second operation
    run_op(VECS[0], 1'b1);
    wcnt = 0;
    repeat (60) @(negedge clk);
    check(wcnt == 0 && busy_o == 1'b0, "R10", "request while busy ignored",
          wcnt, 32'd0);

    check(v_r4 == 0, "R4", "write strobe outside write window", v_r4, 0);
    check(v_r5 == 0, "R5", "write pulse/setup/gap violations", v_r5, 0);
    check(v_r6 == 0, "R6", "data drive overlapping output enable", v_r6, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule